// File: doc/BRIEF.md
# Packed Complex Arithmetic Execution Unit

This execution unit sits in the datapath of a signal-processing core. Each 64-bit operand word packs one complex number: the low half is the signed real part and the high half is the signed imaginary part, both in Q1.31 fixed point. A two-bit opcode selects one of four functions. The unit can sum two complex values, form their complex product, conjugate one value, or bit-reverse an address for FFT index reordering.

The product uses four multipliers that run in parallel. Their results feed one subtractor for the real part and one adder for the imaginary part. Each sum is rounded back to Q1.31 and clamped to the 32-bit signed range. The real and imaginary sums are also clamped rather than allowed to wrap, and so is the conjugate's negation.

Each accepted operation produces its result and a valid flag from one register stage, one clock later. An issue can be accepted on every cycle. Decode, the register file and memory are handled elsewhere.

Top module: `cplx_exec_unit`

## Requirements
- R1: After reset, `out_vld` is 0 and `out_res` is all zeros.
- R2: With opcode 0 (sum), the real result (bits 31:0) is the saturated sum of the two real halves, and the imaginary result (bits 63:32) is the saturated sum of the two imaginary halves. Saturation limits are 0x7FFFFFFF and 0x80000000.
- R3: With opcode 1 (product), the real result is `ar*br - ai*bi` and the imaginary result is `ar*bi + ai*br`. Each is computed at full precision, then 2^30 is added, then it is shifted right arithmetically by 31. This rounds to nearest, with ties going up.
- R4: A product part that falls outside the signed 32-bit range after rounding is clamped to 0x7FFFFFFF or 0x80000000. For example, (-1)·(-1) gives 0x7FFFFFFF.
- R5: With opcode 2 (conjugate), the real half of `in_a` passes through unchanged and its imaginary half is negated. `in_b` has no effect.
- R6: In conjugate, an imaginary half of 0x80000000 becomes 0x7FFFFFFF.
- R7: With opcode 3 (bit reverse), the low N bits of `in_a` come out in reversed order in the low N bits of the result. All bits from N upward are zero.
- R8: For bit reverse, N is taken from `in_b[3:0]`. Values below 3 act as 3 and values above 10 act as 10.
- R9: When `in_vld` is high at a clock edge, the result and `out_vld = 1` appear after that edge. This holds on every cycle, including back-to-back issues with different opcodes.
- R10: When `in_vld` is low at a clock edge, `out_vld` goes to 0 and `out_res` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Issue strobe for the operation on the inputs |
| in_op | input | 2 | Function select: 0 sum, 1 product, 2 conjugate, 3 bit reverse |
| in_a | input | 64 | First operand: imaginary half in 63:32, real half in 31:0; the address for bit reverse |
| in_b | input | 64 | Second operand; bits 3:0 give the reverse width for bit reverse |
| out_vld | output | 1 | Result valid, one cycle after issue |
| out_res | output | 64 | Registered result |

## Verification
Rounding and clamping can both apply to the same product part in the same cycle. Multiplying full-scale negative values gives a value that rounds up past the positive limit, so the clamp has to win over the round increment. Two things are judged separately. A product of exactly half an LSB must round up, and one just under half an LSB must round down. The most negative squared must come out as 0x7FFFFFFF, not wrap to 0x80000000. The vector table also issues on every cycle with the opcode changing between cycles. This checks that a product result and the following bit-reverse or conjugate result each land in their own cycle without mixing.

// File: rtl/cplx_pkg.sv
package cplx_pkg;

   typedef enum logic [1:0] {
      OP_ADD  = 2'd0,
      OP_MUL  = 2'd1,
      OP_CONJ = 2'd2,
      OP_BREV = 2'd3
   } cplx_op_e;

endpackage

// File: rtl/cplx_sat_add.sv
// Saturating add (or subtract-from-zero) of one signed lane.
module cplx_sat_add #(
   parameter int LANE_W = 32,
   parameter bit NEGATE = 1'b0
) (
   input  logic signed [LANE_W-1:0] x,
   input  logic signed [LANE_W-1:0] y,
   output logic signed [LANE_W-1:0] z
);
   localparam logic signed [LANE_W:0] HI = {2'b00, {(LANE_W-1){1'b1}}};
   localparam logic signed [LANE_W:0] LO = {2'b11, {(LANE_W-1){1'b0}}};

   logic signed [LANE_W:0] wide;

   generate
      if (NEGATE) begin : g_neg
         always_comb wide = -$signed({x[LANE_W-1], x});
      end else begin : g_add
         always_comb wide = $signed({x[LANE_W-1], x}) + $signed({y[LANE_W-1], y});
      end
   endgenerate

   always_comb begin
      if (wide > HI)      z = HI[LANE_W-1:0];
      else if (wide < LO) z = LO[LANE_W-1:0];
      else                z = wide[LANE_W-1:0];
   end
endmodule

// File: rtl/cplx_mul_part.sv
// One part of a complex product: x0*y0 +/- x1*y1, rounded and clamped.
module cplx_mul_part #(
   parameter int LANE_W   = 32,
   parameter int FRAC_W   = 31,
   parameter bit SUBTRACT = 1'b0
) (
   input  logic signed [LANE_W-1:0] x0,
   input  logic signed [LANE_W-1:0] y0,
   input  logic signed [LANE_W-1:0] x1,
   input  logic signed [LANE_W-1:0] y1,
   output logic signed [LANE_W-1:0] z
);
   localparam int PW = 2 * LANE_W;
   localparam int SW = PW + 1;
   localparam logic signed [SW-1:0] HALF = SW'(1) <<< (FRAC_W - 1);
   localparam logic signed [SW-1:0] HI = (SW'(1) <<< (LANE_W - 1)) - SW'(1);
   localparam logic signed [SW-1:0] LO = -(SW'(1) <<< (LANE_W - 1));

   logic signed [PW-1:0] p0, p1;
   logic signed [SW-1:0] acc, rnd;

   always_comb begin
      p0 = PW'(x0) * PW'(y0);
      p1 = PW'(x1) * PW'(y1);
   end

   generate
      if (SUBTRACT) begin : g_sub
         always_comb acc = SW'(p0) - SW'(p1);
      end else begin : g_add
         always_comb acc = SW'(p0) + SW'(p1);
      end
   endgenerate

   always_comb begin
      rnd = (acc + HALF) >>> FRAC_W;
      if (rnd > HI)      z = HI[LANE_W-1:0];
      else if (rnd < LO) z = LO[LANE_W-1:0];
      else               z = rnd[LANE_W-1:0];
   end
endmodule

// File: rtl/cplx_bitrev.sv
// Run-time width bit reversal for FFT index reordering.
module cplx_bitrev #(
   parameter int DATA_W   = 64,
   parameter int MIN_BITS = 3,
   parameter int MAX_BITS = 10,
   parameter int WID_W    = 4
) (
   input  logic [DATA_W-1:0] addr,
   input  logic [WID_W-1:0]  width,
   output logic [DATA_W-1:0] rev
);
   logic [DATA_W-1:0] cand [MIN_BITS:MAX_BITS];
   logic [WID_W-1:0]  n_eff;

   genvar k, i;
   generate
      for (k = MIN_BITS; k <= MAX_BITS; k++) begin : g_w
         for (i = 0; i < DATA_W; i++) begin : g_b
            if (i < k) begin : g_in
               assign cand[k][i] = addr[k-1-i];
            end else begin : g_zero
               assign cand[k][i] = 1'b0;
            end
         end
      end
   endgenerate

   always_comb begin
      if (width < WID_W'(MIN_BITS))      n_eff = WID_W'(MIN_BITS);
      else if (width > WID_W'(MAX_BITS)) n_eff = WID_W'(MAX_BITS);
      else                               n_eff = width;
      rev = '0;
      for (int w = MIN_BITS; w <= MAX_BITS; w++)
         if (n_eff == WID_W'(w)) rev = cand[w];
   end
endmodule

// File: rtl/cplx_exec_unit.sv
module cplx_exec_unit #(
   parameter int LANE_W   = 32,
   parameter int FRAC_W   = 31,
   parameter int BREV_MIN = 3,
   parameter int BREV_MAX = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_vld,
   input  logic [1:0]          in_op,
   input  logic [2*LANE_W-1:0] in_a,
   input  logic [2*LANE_W-1:0] in_b,
   output logic                out_vld,
   output logic [2*LANE_W-1:0] out_res
);
   import cplx_pkg::*;

   localparam int DATA_W = 2 * LANE_W;
   localparam int WID_W  = $clog2(BREV_MAX + 1);

   initial begin
      assert (FRAC_W > 0 && FRAC_W < LANE_W) else $error("FRAC_W out of range");
      assert (BREV_MIN >= 1 && BREV_MIN <= BREV_MAX) else $error("bad reverse limits");
      assert (BREV_MAX <= DATA_W) else $error("BREV_MAX exceeds word");
   end

   logic signed [LANE_W-1:0] a_re, a_im, b_re, b_im;
   logic signed [LANE_W-1:0] sum_re, sum_im, mul_re, mul_im, cj_im;
   logic [DATA_W-1:0]        brev_res, nxt;
   cplx_op_e                 op;

   always_comb begin
      a_re = in_a[LANE_W-1:0];
      a_im = in_a[DATA_W-1:LANE_W];
      b_re = in_b[LANE_W-1:0];
      b_im = in_b[DATA_W-1:LANE_W];
      op   = cplx_op_e'(in_op);
   end

   cplx_sat_add #(.LANE_W(LANE_W), .NEGATE(1'b0)) u_add_re (.x(a_re), .y(b_re), .z(sum_re));
   cplx_sat_add #(.LANE_W(LANE_W), .NEGATE(1'b0)) u_add_im (.x(a_im), .y(b_im), .z(sum_im));
   cplx_sat_add #(.LANE_W(LANE_W), .NEGATE(1'b1)) u_conj   (.x(a_im), .y(b_im), .z(cj_im));

   cplx_mul_part #(.LANE_W(LANE_W), .FRAC_W(FRAC_W), .SUBTRACT(1'b1)) u_mul_re (
      .x0(a_re), .y0(b_re), .x1(a_im), .y1(b_im), .z(mul_re));
   cplx_mul_part #(.LANE_W(LANE_W), .FRAC_W(FRAC_W), .SUBTRACT(1'b0)) u_mul_im (
      .x0(a_re), .y0(b_im), .x1(a_im), .y1(b_re), .z(mul_im));

   cplx_bitrev #(.DATA_W(DATA_W), .MIN_BITS(BREV_MIN), .MAX_BITS(BREV_MAX), .WID_W(WID_W)) u_brev (
      .addr(in_a), .width(in_b[WID_W-1:0]), .rev(brev_res));

   always_comb begin
      unique case (op)
         OP_ADD:  nxt = {sum_im, sum_re};
         OP_MUL:  nxt = {mul_im, mul_re};
         OP_CONJ: nxt = {cj_im, a_re};
         default: nxt = brev_res;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld <= 1'b0;
         out_res <= '0;
      end else begin
         out_vld <= in_vld;
         if (in_vld) out_res <= nxt;
      end
   end

   // R9
   issue_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> out_vld);

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> (!out_vld && $stable(out_res)));

   // R7
   brev_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_op == 2'd3) |=> out_res[DATA_W-1:BREV_MAX] == '0);

   // R5
   conj_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_op == 2'd2) |=> out_res[LANE_W-1:0] == $past(in_a[LANE_W-1:0]));

   // R2
   add_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && in_op == 2'd0 && !in_a[LANE_W-1] && !in_b[LANE_W-1]) |=> !out_res[LANE_W-1]);
endmodule

// File: tb/sim_cplx_exec_unit.sv
module sim_cplx_exec_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_vld = 1'b0;
   logic [1:0]  in_op = 2'd0;
   logic [63:0] in_a = '0, in_b = '0;
   logic        out_vld;
   logic [63:0] out_res;
   int total = 0, bad = 0;

   always #2 clk = ~clk;

   cplx_exec_unit u0 (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
                      .in_a(in_a), .in_b(in_b), .out_vld(out_vld), .out_res(out_res));

   typedef struct packed {
      logic [1:0]  op;
      logic [63:0] a;
      logic [63:0] b;
      logic [63:0] exp;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      // R2 plain sum
      '{2'd0, 64'h10000000_20000000, 64'h01000000_00000003, 64'h11000000_20000003, 8'd2},
      // R2 both lanes clamp
      '{2'd0, 64'h80000000_7FFFFFF0, 64'hFFFFFFFF_00000100, 64'h80000000_7FFFFFFF, 8'd2},
      // R3 (0.5+0.5j)(0.5-0.5j)
      '{2'd1, 64'h40000000_40000000, 64'hC0000000_40000000, 64'h00000000_40000000, 8'd3},
      // R4 (-1)(-1) clamps
      '{2'd1, 64'h00000000_80000000, 64'h00000000_80000000, 64'h00000000_7FFFFFFF, 8'd4},
      // R3 tie rounds up in real, just under half rounds down in imag
      '{2'd1, 64'h00000000_00000001, 64'h3FFFFFFF_40000000, 64'h00000000_00000001, 8'd3},
      // R3 general product
      '{2'd1, 64'h20000000_40000000, 64'h40000000_20000000, 64'h28000000_00000000, 8'd3},
      // R5 conjugate, in_b ignored
      '{2'd2, 64'h12345678_0ABCDEF0, 64'hDEADBEEF_CAFEF00D, 64'hEDCBA988_0ABCDEF0, 8'd5},
      // R6 conjugate of most negative imag
      '{2'd2, 64'h80000000_00000005, 64'h0, 64'h7FFFFFFF_00000005, 8'd6},
      // R7 width 3, garbage above
      '{2'd3, 64'hFFFFFFFF_FFFFFFF1, 64'h3, 64'h4, 8'd7},
      // R7 width 10
      '{2'd3, 64'hABCD0000_00000403, 64'hA, 64'h300, 8'd7},
      // R7 width 4
      '{2'd3, 64'h0B, 64'h4, 64'hD, 8'd7},
      // R8 width 1 acts as 3
      '{2'd3, 64'h6, 64'h1, 64'h3, 8'd8},
      // R8 width 15 acts as 10
      '{2'd3, 64'h200, 64'hF, 64'h1, 8'd8},
      // R2 negative sum
      '{2'd0, 64'hF0000000_C0000000, 64'hF0000000_E0000000, 64'hE0000000_A0000000, 8'd2}
   };

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input int req);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL R%0d act=%h exp=%h", req, act, exp);
      end
   endtask

   initial begin : watchdog
      #400000;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk({63'd0, out_vld}, 64'd0, 1);
      chk(out_res, 64'd0, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk({63'd0, out_vld}, 64'd0, 1);

      // back-to-back walk of the table (R9)
      for (int v = 0; v < NV; v++) begin
         in_vld = 1'b1;
         in_op  = VECS[v].op;
         in_a   = VECS[v].a;
         in_b   = VECS[v].b;
         @(negedge clk);
         chk({63'd0, out_vld}, 64'd1, 9);
         chk(out_res, VECS[v].exp, int'(VECS[v].req));
      end

      // R10 idle cycles hold the result while inputs change
      in_vld = 1'b0;
      in_op  = 2'd0;
      in_a   = 64'h11111111_11111111;
      in_b   = 64'h22222222_22222222;
      @(negedge clk);
      chk({63'd0, out_vld}, 64'd0, 10);
      chk(out_res, VECS[NV-1].exp, 10);
      @(negedge clk);
      chk(out_res, VECS[NV-1].exp, 10);

      // R9 single issue after idle, then idle again
      in_vld = 1'b1;
      in_op  = 2'd1;
      in_a   = 64'h00000000_40000000;
      in_b   = 64'h00000000_40000000;
      @(negedge clk);
      in_vld = 1'b0;
      chk({63'd0, out_vld}, 64'd1, 9);
      chk(out_res, 64'h00000000_20000000, 3);
      @(negedge clk);
      chk({63'd0, out_vld}, 64'd0, 10);

      // R1 reset mid-run clears result
      rst_n = 1'b0;
      @(negedge clk);
      chk(out_res, 64'd0, 1);
      rst_n = 1'b1;
      @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule